// File: doc/BRIEF.md
# Battery Charge Phase Sequencer

This block is the digital sequencer of a single-cell battery charger. It walks the charger through its phases: idle, prequalification, fast charge, top-off, done, and a latched timer fault. It decides when the analog charge path may draw current, and it drives an active-low status line. Comparator flags from the analog side tell it when the battery has passed the prequalification threshold, when the loop has moved into constant-voltage regulation, when the current has fallen below the top-off level, and which band the delivered current falls in, as a fraction of the programmed fast-charge level.

Every phase that can stall has a fault timer. These timers count minutes from a prescaler that is set by parameters, so a test can shrink the time base. In the constant-current part of fast charge, the timer slows down or stops when external limits cut the delivered current. This avoids spurious faults. After a timer fault the status line blinks until a system-level reset condition clears it.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While `chg_en` is low or `supply_ok` is low, the controller enters idle on the next clock edge, and `charge_req` is low in idle.
- R2: Idle moves to prequalification on the edge after `chg_en` and `supply_ok` are both high. Prequalification moves to fast charge on the edge after `batt_above_thr` is seen high, and this takes priority over timer expiry.
- R3: If prequalification lasts `PREQ_MIN` minute ticks without the threshold being reached, the controller enters the fault phase.
- R4: In fast charge with `cv_mode` low and `cur_band` = 2'b10 or 2'b11 (current at 50 % or more of the programmed level), the timer advances one unit per minute tick. Fault follows after `FAST_MIN` ticks.
- R5: In fast charge with `cv_mode` low, `cur_band` = 2'b01 (20 % to 50 %) advances the timer at half rate, and `cur_band` = 2'b00 (below 20 %) freezes it. Half-rate progress carries over between bands.
- R6: In fast charge with `cv_mode` high, the timer advances at full rate whatever `cur_band` is.
- R7: Fast charge moves to top-off on the edge after `cv_mode` and `below_topoff` are both high. This takes priority over expiry. Top-off lasts `TOPOFF_MIN` ticks and then moves to done. Done holds while charging is allowed, and `charge_req` is low in done.
- R8: `stat_n` is low in prequalification and fast charge, and high in idle, top-off and done. `charge_req` is high in prequalification, fast charge and top-off.
- R9: In the fault phase `charge_req` is low and `stat_n` starts low. It then toggles every `CYC_PER_BLINK` clocks, which is a quarter of a second for a 2 Hz blink.
- R10: The fault phase is left, to idle, only when `chg_en` goes low, `supply_ok` goes low, or `lim_sel` equals 2'b11. Other `lim_sel` values leave it in fault.
- R11: `phase` encodes idle=0, prequalification=1, fast charge=2, top-off=3, done=4, fault=5. The minute prescaler and the phase timer restart on every phase change, so a phase with limit L lasts L·`CYC_PER_MIN`+1 clocks before it expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_en | input | 1 | Charger enable from the host |
| supply_ok | input | 1 | Input supply is valid |
| lim_sel | input | 2 | Limit-select field; 2'b11 clears a fault |
| batt_above_thr | input | 1 | Battery above prequalification threshold |
| cv_mode | input | 1 | Charge loop is in constant-voltage regulation |
| below_topoff | input | 1 | Charge current below top-off level |
| cur_band | input | 2 | Delivered current band (00 <20 %, 01 20–50 %, 1x ≥50 %) |
| phase | output | 3 | Current phase code |
| charge_req | output | 1 | Request to the analog charge path |
| stat_n | output | 1 | Active-low status, blinks in fault |

## Verification
The assertions check the following on every cycle: the gating by enable and supply, the status and request levels in each phase, that the fault phase holds or clears correctly under `lim_sel`, that blinking starts low, and that done holds. Only the bench scenarios can show exact durations. These are the timer lengths for each phase, the half-rate and frozen accounting over random sequences of current bands, the full rate under constant voltage, and the blink period, because each depends on counting many minute ticks.

// File: rtl/chg_seq_pkg.sv
// Shared phase encoding and current-band codes for the charge sequencer.
package chg_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_PREQ   = 3'd1,
        PH_FAST   = 3'd2,
        PH_TOPOFF = 3'd3,
        PH_DONE   = 3'd4,
        PH_FAULT  = 3'd5
    } phase_t;

    localparam logic [1:0] BAND_LOW  = 2'b00;  // below 20 %: timer frozen
    localparam logic [1:0] BAND_MID  = 2'b01;  // 20..50 %: half rate
    localparam logic [1:0] LIM_CLEAR = 2'b11;  // clears a latched fault
endpackage

// File: rtl/chg_tick_gen.sv
// Time base: a minute-tick prescaler that restarts on request, and a
// blink level that starts low and toggles every CYC_PER_BLINK clocks
// while enabled. Assumes both parameters are at least 1.
module chg_tick_gen #(
    parameter int CYC_PER_MIN   = 60_000_000,
    parameter int CYC_PER_BLINK = 250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic blink_run,
    output logic min_tick,
    output logic blink_lvl
);
    localparam int MIN_W = $clog2(CYC_PER_MIN + 1);
    localparam int BLK_W = $clog2(CYC_PER_BLINK + 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYC_PER_MIN - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(CYC_PER_BLINK - 1);

    logic [MIN_W-1:0] min_cnt;
    logic [BLK_W-1:0] blk_cnt;

    assign min_tick = !restart && (min_cnt == MIN_LAST);

    // Minute prescaler, cleared on every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || min_tick) min_cnt <= '0;
        else                               min_cnt <= min_cnt + 1'b1;
    end

    // Blink divider, held low while the fault phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !blink_run) begin
            blk_cnt   <= '0;
            blink_lvl <= 1'b0;
        end else if (blk_cnt == BLK_LAST) begin
            blk_cnt   <= '0;
            blink_lvl <= !blink_lvl;
        end else begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/chg_phase_timer.sv
// Phase fault timer: counts minute ticks at full or half rate and flags
// expiry when the count reaches the limit. The half-rate remainder is kept
// across rate changes. Assumes the limit fits in CNT_W bits.
module chg_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             min_tick,
    input  logic             rate_full,
    input  logic             rate_half,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] count;
    logic             half_acc;

    assign expired = (count == limit);

    // Advance the minute count; a half-rate tick completes a unit every second time.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count    <= '0;
            half_acc <= 1'b0;
        end else if (min_tick && !expired) begin
            if (rate_full) begin
                count <= count + 1'b1;
            end else if (rate_half) begin
                half_acc <= !half_acc;
                if (half_acc) count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/chg_phase_fsm.sv
// Phase state machine: it gates on enable and supply, moves forward on the
// comparator flags, falls into fault on expiry, and leaves fault only
// through the clearing conditions. It also raises a restart pulse whenever
// the phase is about to change.
module chg_phase_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_en,
    input  logic       supply_ok,
    input  logic [1:0] lim_sel,
    input  logic       batt_above_thr,
    input  logic       cv_mode,
    input  logic       below_topoff,
    input  logic       expired,
    output phase_t     phase,
    output logic       restart
);
    phase_t nxt;

    // Next-phase decision; a forward move takes priority over expiry.
    always_comb begin
        nxt = phase;
        if (!(chg_en && supply_ok)) begin
            nxt = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:   nxt = PH_PREQ;
                PH_PREQ:   if (batt_above_thr)           nxt = PH_FAST;
                           else if (expired)             nxt = PH_FAULT;
                PH_FAST:   if (cv_mode && below_topoff)  nxt = PH_TOPOFF;
                           else if (expired)             nxt = PH_FAULT;
                PH_TOPOFF: if (expired)                  nxt = PH_DONE;
                PH_DONE:   nxt = PH_DONE;
                PH_FAULT:  if (lim_sel == LIM_CLEAR)     nxt = PH_IDLE;
                default:   nxt = PH_IDLE;
            endcase
        end
    end

    assign restart = (nxt != phase);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end
endmodule

// File: rtl/chg_seq_ctrl.sv
// Charge sequencer top: it wires the time base, the phase timer and the
// phase machine together, picks the limit and rate for each phase, and
// drives the request and status outputs. Time parameters are in clocks
// per minute and clocks per blink half-period.
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int CYC_PER_MIN   = 60_000_000,
    parameter int CYC_PER_BLINK = 250_000,
    parameter int PREQ_MIN      = 33,
    parameter int FAST_MIN      = 660,
    parameter int TOPOFF_MIN    = 33
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_en,
    input  logic       supply_ok,
    input  logic [1:0] lim_sel,
    input  logic       batt_above_thr,
    input  logic       cv_mode,
    input  logic       below_topoff,
    input  logic [1:0] cur_band,
    output logic [2:0] phase,
    output logic       charge_req,
    output logic       stat_n
);
    localparam int MAX_MIN = (FAST_MIN > PREQ_MIN)
                           ? ((FAST_MIN > TOPOFF_MIN) ? FAST_MIN : TOPOFF_MIN)
                           : ((PREQ_MIN > TOPOFF_MIN) ? PREQ_MIN : TOPOFF_MIN);
    localparam int CNT_W = $clog2(MAX_MIN + 1);
    localparam logic [CNT_W-1:0] LIM_PREQ = CNT_W'(PREQ_MIN);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(FAST_MIN);
    localparam logic [CNT_W-1:0] LIM_TOP  = CNT_W'(TOPOFF_MIN);

    phase_t           ph;
    logic             restart, min_tick, blink_lvl, expired;
    logic             rate_full, rate_half;
    logic [CNT_W-1:0] limit;

    chg_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .supply_ok(supply_ok),
        .lim_sel(lim_sel), .batt_above_thr(batt_above_thr), .cv_mode(cv_mode),
        .below_topoff(below_topoff), .expired(expired), .phase(ph),
        .restart(restart)
    );

    chg_tick_gen #(.CYC_PER_MIN(CYC_PER_MIN), .CYC_PER_BLINK(CYC_PER_BLINK)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .blink_run(ph == PH_FAULT), .min_tick(min_tick), .blink_lvl(blink_lvl)
    );

    chg_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .min_tick(min_tick),
        .rate_full(rate_full), .rate_half(rate_half), .limit(limit),
        .expired(expired)
    );

    // Limit and advance rate for each phase; band scaling only in constant current.
    always_comb begin
        limit     = LIM_PREQ;
        rate_full = 1'b0;
        rate_half = 1'b0;
        unique case (ph)
            PH_PREQ:   rate_full = 1'b1;
            PH_TOPOFF: begin limit = LIM_TOP; rate_full = 1'b1; end
            PH_FAST: begin
                limit = LIM_FAST;
                if (cv_mode || cur_band[1]) rate_full = 1'b1;
                else if (cur_band == BAND_MID) rate_half = 1'b1;
            end
            default: ;
        endcase
    end

    // Output decode: request while current may flow, status low while charging or blinking.
    always_comb begin
        phase      = ph;
        charge_req = (ph == PH_PREQ) || (ph == PH_FAST) || (ph == PH_TOPOFF);
        unique case (ph)
            PH_PREQ, PH_FAST: stat_n = 1'b0;
            PH_FAULT:         stat_n = blink_lvl;
            default:          stat_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/chg_seq_ctrl_chk.sv
// Property checker for the charge sequencer, bound to every instance.
// It observes top-level ports only.
module chg_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_en,
    input logic       supply_ok,
    input logic [1:0] lim_sel,
    input logic [2:0] phase,
    input logic       charge_req,
    input logic       stat_n
);
    localparam logic [2:0] IDLE = 3'd0, PREQ = 3'd1, FAST = 3'd2,
                           TOP = 3'd3, DONE = 3'd4, FLT = 3'd5;

    p_gate_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_en && supply_ok) |=> (phase == IDLE) && !charge_req);

    p_phase_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= FLT);

    p_stat_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PREQ || phase == FAST) |-> !stat_n && charge_req);

    p_stat_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == IDLE || phase == TOP || phase == DONE) |-> stat_n);

    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FLT && chg_en && supply_ok && lim_sel != 2'b11) |=> phase == FLT);

    p_fault_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FLT && lim_sel == 2'b11) |=> phase == IDLE);

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == FLT |-> !charge_req);

    p_blink_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phase != FLT |=> (phase != FLT) || !stat_n);

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == DONE && chg_en && supply_ok) |=> phase == DONE && !charge_req);
endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .supply_ok(supply_ok),
    .lim_sel(lim_sel), .phase(phase), .charge_req(charge_req), .stat_n(stat_n)
);

// File: tb/chg_seq_ctrl_tb.sv
module chg_seq_ctrl_tb;
    localparam int CYC   = 4;
    localparam int HALF  = 3;
    localparam int LPREQ = 3;
    localparam int LFAST = 5;
    localparam int LTOP  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chg_en = 1'b0, supply_ok = 1'b0;
    logic [1:0] lim_sel = 2'b00;
    logic       batt_above_thr = 1'b0, cv_mode = 1'b0, below_topoff = 1'b0;
    logic [1:0] cur_band = 2'b10;
    logic [2:0] phase;
    logic       charge_req, stat_n;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = !clk;

    chg_seq_ctrl #(.CYC_PER_MIN(CYC), .CYC_PER_BLINK(HALF), .PREQ_MIN(LPREQ),
                   .FAST_MIN(LFAST), .TOPOFF_MIN(LTOP)) u_dut (
        .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .supply_ok(supply_ok),
        .lim_sel(lim_sel), .batt_above_thr(batt_above_thr), .cv_mode(cv_mode),
        .below_topoff(below_topoff), .cur_band(cur_band), .phase(phase),
        .charge_req(charge_req), .stat_n(stat_n));

    // Expected clocks spent in a timed phase of limit L at full rate.
    function automatic int exp_len(input int lim, input int div);
        return lim * CYC * div + 1;
    endfunction

    // Timer credit in half units added by one minute tick in constant current.
    function automatic int band_credit(input logic [1:0] b);
        return b[1] ? 2 : (b == 2'b01 ? 1 : 0);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges spent in phase ph, starting at the entry negedge.
    task automatic run_len(input logic [2:0] ph, output int n);
        n = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (phase !== ph) break;
            n++;
        end
    endtask

    // From any phase: drop enable for one cycle and return at the idle negedge.
    task automatic go_idle();
        chg_en = 1'b0;
        @(negedge clk);
        chg_en = 1'b1;
    endtask

    // Enter fast charge; return at the negedge of entry.
    task automatic enter_fast(input logic cv, input logic [1:0] band);
        go_idle();
        cv_mode = cv; cur_band = band; below_topoff = 1'b0;
        batt_above_thr = 1'b1; supply_ok = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(phase == 3'd2, "R2 enter fast", phase, 2);
    endtask

    initial begin
        int n, units;
        bit hit;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase == 3'd0 && !charge_req && stat_n, "R11 reset idle", phase, 0);

        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk(phase == 3'd0 && !charge_req, "R1 held idle without enable", phase, 0);

        chg_en = 1'b1;
        @(negedge clk);
        chk(phase == 3'd1, "R2 idle to prequal", phase, 1);
        chk(!stat_n && charge_req, "R8 prequal status", stat_n, 0);

        run_len(3'd1, n);
        chk(n == exp_len(LPREQ, 1), "R3 prequal duration", n, exp_len(LPREQ, 1));
        chk(phase == 3'd5, "R3 prequal timeout fault", phase, 5);

        lim_sel = 2'b01;
        for (int i = 0; i < 4 * HALF; i++) begin
            chk(stat_n == ((i / HALF) % 2), "R9 blink level", stat_n, (i / HALF) % 2);
            chk(phase == 3'd5 && !charge_req, "R10 fault held", phase, 5);
            if (i == 2 * HALF) lim_sel = 2'b10;
            @(negedge clk);
        end
        lim_sel = 2'b11;
        @(negedge clk);
        chk(phase == 3'd0, "R10 clear by limit field", phase, 0);
        lim_sel = 2'b00;
        @(negedge clk);
        chk(phase == 3'd1, "R2 restart prequal", phase, 1);

        batt_above_thr = 1'b1;
        @(negedge clk);
        chk(phase == 3'd2 && !stat_n, "R2 prequal to fast", phase, 2);
        run_len(3'd2, n);
        chk(n == exp_len(LFAST, 1), "R4 fast full rate duration", n, exp_len(LFAST, 1));
        chk(phase == 3'd5, "R4 fast timeout fault", phase, 5);
        supply_ok = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0 && !charge_req, "R10 clear by supply loss", phase, 0);

        enter_fast(1'b0, 2'b01);
        run_len(3'd2, n);
        chk(n == exp_len(LFAST, 2), "R5 half rate duration", n, exp_len(LFAST, 2));

        enter_fast(1'b0, 2'b00);
        repeat (LFAST * CYC * 3) @(negedge clk);
        chk(phase == 3'd2, "R5 frozen timer", phase, 2);

        enter_fast(1'b1, 2'b00);
        run_len(3'd2, n);
        chk(n == exp_len(LFAST, 1), "R6 cv full rate", n, exp_len(LFAST, 1));

        for (int ep = 0; ep < 6; ep++) begin
            enter_fast(1'b0, 2'($urandom % 4));
            units = 0; hit = 0;
            for (int w = 0; w < 40 && !hit; w++) begin
                if (w > 0) cur_band = 2'($urandom % 4);
                repeat (CYC) @(negedge clk);
                units += band_credit(cur_band);
                chk(phase == 3'd2, "R5 random still fast", phase, 2);
                if (units >= 2 * LFAST) begin
                    hit = 1;
                    @(negedge clk);
                    chk(phase == 3'd5, "R5 random expiry", phase, 5);
                end
            end
        end

        enter_fast(1'b0, 2'b10);
        repeat (5) @(negedge clk);
        cv_mode = 1'b1; below_topoff = 1'b1;
        @(negedge clk);
        chk(phase == 3'd3 && stat_n && charge_req, "R7 fast to topoff", phase, 3);
        run_len(3'd3, n);
        chk(n == exp_len(LTOP, 1), "R7 topoff duration", n, exp_len(LTOP, 1));
        repeat (10) @(negedge clk);
        chk(phase == 3'd4 && !charge_req && stat_n, "R7 done holds", phase, 4);

        go_idle();
        cv_mode = 1'b0; below_topoff = 1'b0; batt_above_thr = 1'b0;
        @(negedge clk);
        run_len(3'd1, n);
        chk(phase == 3'd5, "R3 second prequal fault", phase, 5);
        chg_en = 1'b0;
        @(negedge clk);
        chk(phase == 3'd0, "R10 clear by enable low", phase, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule